// File: doc/BRIEF.md
# Programmable periodic interrupt divider

This block derives periodic interrupt events from a 32768 Hz timebase that reaches it as a single-cycle tick enable in the system clock domain. A 4-bit rate code and an enable bit choose the event period. Both are captured only on a configuration strobe, which the owning register file raises whenever either of its control registers is written. The block emits a one-cycle event pulse that the status logic uses to set its periodic and request flags. It also shows the currently active period in ticks for observation.

Events are not timed from the moment of configuration. A free-running 15-bit tick counter keeps the phase, and an event fires when that counter lands on a multiple of the active period. Re-programming the rate therefore keeps every event on the common phase grid. The first event after a write falls on the next multiple above the current count.

Top module: `periodic_divider`

## Requirements
- R1: After reset, `evt_o` and `period_o` are 0, the phase counter is 0, and the captured configuration is rate code 6 with the enable clear.
- R2: The phase counter advances by one only in cycles where `tick_i` is high. It wraps from 32767 to 0. Cycles without a tick never produce an event.
- R3: Rate code 0 produces no events and shows `period_o` = 0, whatever the enable bit is.
- R4: With the enable bit clear, no events occur and `period_o` = 0, whatever the rate code is.
- R5: For rate codes 3 to 15, the period is 2^(code-1) ticks: 4 ticks for code 3, up to 16384 ticks for code 15.
- R6: Rate code 1 gives a period of 128 ticks and rate code 2 gives 256 ticks, the same periods as codes 8 and 9.
- R7: An event is due on the tick after which the phase counter is an exact multiple of the active period. This holds whenever the configuration was written.
- R8: `rate_sel_i` and `pie_i` are captured only in cycles with `cfg_wr_i` high. Changes in other cycles affect neither `evt_o` nor `period_o`.
- R9: A configuration written in a cycle already governs that cycle's event decision. In particular, writing the enable clear in the cycle of a due tick suppresses that event.
- R10: `evt_o` is high for exactly one cycle. It rises in the cycle that follows the clock edge sampling the completing tick, which is the same edge that advances the counter.
- R11: `period_o` shows the period of the captured configuration, or 0 when inactive. It changes in the cycle after a configuration write and holds steady otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 32768 Hz tick enable, one cycle wide |
| rate_sel_i | input | 4 | Rate code, 0 disables |
| pie_i | input | 1 | Periodic event enable |
| cfg_wr_i | input | 1 | Capture strobe for `rate_sel_i` and `pie_i` |
| evt_o | output | 1 | Periodic event pulse |
| period_o | output | 15 | Active period in ticks, 0 when inactive |

## Verification
Every result of this block is due one clock edge after the inputs that cause it. The event decision for a tick sampled at one edge appears on `evt_o` just after that edge. A configuration captured at an edge shows on `period_o` from that edge on. The driver sets the inputs at the falling edge and pushes the expected pair for the next rising edge into a queue. The monitor pops and compares that pair shortly after the rising edge, so every comparison lands exactly one edge after its stimulus. The expected values come from a reference count of ticks and the captured configuration, with the period computed from the rate-code rules alone.

// File: rtl/periodic_divider_pkg.sv
package periodic_divider_pkg;
  localparam int unsigned PH_W    = 15;  // phase counter width
  localparam int unsigned CODE_W  = 4;   // rate code width
  localparam int unsigned LOW_MAX = 2;   // codes folded upward
  localparam int unsigned FOLD    = 7;   // fold offset for low codes

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic              en;
  } rate_cfg_t;
endpackage

// File: rtl/pd_phase_cnt.sv
module pd_phase_cnt #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_nxt_o = cnt_q + CNT_W'(1);
  assign cnt_o     = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_nxt_o;
  end
endmodule

// File: rtl/pd_rate_dec.sv
module pd_rate_dec
  import periodic_divider_pkg::*;
#(
  parameter int unsigned CNT_W = PH_W
) (
  input  rate_cfg_t        cfg_i,
  output logic             active_o,
  output logic [CNT_W-1:0] period_o,
  output logic [CNT_W-1:0] mask_o
);
  localparam int unsigned SH_W = $clog2(CNT_W);

  logic [SH_W-1:0] shift;

  always_comb begin
    // low codes alias onto longer periods
    if (int'(cfg_i.code) <= LOW_MAX) shift = SH_W'(int'(cfg_i.code) + FOLD - 1);
    else                             shift = SH_W'(int'(cfg_i.code) - 1);
  end

  assign active_o = cfg_i.en && (cfg_i.code != '0);
  assign period_o = active_o ? (CNT_W'(1) << shift) : '0;
  assign mask_o   = period_o - CNT_W'(active_o);
endmodule

// File: rtl/pd_cfg_reg.sv
module pd_cfg_reg
  import periodic_divider_pkg::*;
#(
  parameter rate_cfg_t RST_CFG = '{code: CODE_W'(6), en: 1'b0}
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_i,
  input  rate_cfg_t cfg_i,
  output rate_cfg_t cfg_o,
  output rate_cfg_t eff_o
);
  rate_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= RST_CFG;
    else if (wr_i) cfg_q <= cfg_i;
  end

  assign cfg_o = cfg_q;
  // a write governs the decision of its own cycle
  assign eff_o = wr_i ? cfg_i : cfg_q;
endmodule

// File: rtl/periodic_divider.sv
module periodic_divider
  import periodic_divider_pkg::*;
#(
  parameter int unsigned CNT_W  = PH_W,
  parameter int unsigned SEL_W  = CODE_W,
  parameter int unsigned RST_SEL = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [SEL_W-1:0] rate_sel_i,
  input  logic             pie_i,
  input  logic             cfg_wr_i,
  output logic             evt_o,
  output logic [CNT_W-1:0] period_o
);
  localparam rate_cfg_t RST_CFG = '{code: CODE_W'(RST_SEL), en: 1'b0};

  rate_cfg_t        cfg_in, cfg_cur, cfg_eff;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [CNT_W-1:0] eff_period, eff_mask, cur_mask;
  logic             eff_active, cur_active;
  logic             evt_d, evt_q;

  assign cfg_in = '{code: CODE_W'(rate_sel_i), en: pie_i};

  pd_phase_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk_i, .rst_ni, .tick_i,
    .cnt_o(cnt_q), .cnt_nxt_o(cnt_nxt)
  );

  pd_cfg_reg #(.RST_CFG(RST_CFG)) i_cfg (
    .clk_i, .rst_ni, .wr_i(cfg_wr_i),
    .cfg_i(cfg_in), .cfg_o(cfg_cur), .eff_o(cfg_eff)
  );

  pd_rate_dec #(.CNT_W(CNT_W)) i_dec_eff (
    .cfg_i(cfg_eff), .active_o(eff_active),
    .period_o(eff_period), .mask_o(eff_mask)
  );

  pd_rate_dec #(.CNT_W(CNT_W)) i_dec_cur (
    .cfg_i(cfg_cur), .active_o(cur_active),
    .period_o(period_o), .mask_o(cur_mask)
  );

  assign evt_d = tick_i && eff_active && ((cnt_nxt & eff_mask) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= 1'b0;
    else         evt_q <= evt_d;
  end

  assign evt_o = evt_q;
endmodule

// File: rtl/periodic_divider_chk.sv
module periodic_divider_chk #(
  parameter int unsigned CNT_W = 15
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             cfg_wr_i,
  input logic             evt_o,
  input logic [CNT_W-1:0] period_o,
  input logic [CNT_W-1:0] cnt_i
);
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> cnt_i == CNT_W'($past(cnt_i) + 1'b1)); // R2
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_i)); // R2
  AST_EVT_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> period_o != '0); // R4
  AST_PERIOD_POW2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(period_o)); // R5
  AST_EVT_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> (cnt_i & (period_o - 1'b1)) == '0); // R7
  AST_PERIOD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_wr_i |=> $stable(period_o)); // R8
  AST_EVT_AFTER_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> $past(tick_i)); // R10
  AST_EVT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> !evt_o); // R10
endmodule

bind periodic_divider periodic_divider_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .cfg_wr_i(cfg_wr_i),
  .evt_o(evt_o), .period_o(period_o), .cnt_i(cnt_q)
);

// File: tb/test_periodic_divider.sv
module test_periodic_divider;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic [3:0]  rate_sel_i = 4'd0;
  logic        pie_i = 1'b0;
  logic        cfg_wr_i = 1'b0;
  logic        evt_o;
  logic [14:0] period_o;

  periodic_divider i_periodic_divider (.*);

  always #4 clk_i = ~clk_i;  // 125 MHz

  typedef struct {
    bit    evt;
    int    per;
    string tag;
  } exp_t;

  exp_t  q[$];
  int    n_chk = 0, n_fail = 0;
  bit    done = 0;
  int    m_cnt = 0, m_sel = 6;
  bit    m_en = 0;
  string tag = "R1";

  function automatic int per_of(int sel, bit en);
    int s;
    if (!en || sel == 0) return 0;
    s = (sel <= 2) ? sel + 6 : sel - 1;
    return 1 << s;
  endfunction

  task automatic chk(string r, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic step(bit t, int sel, bit en, bit wr);
    exp_t e;
    int esel, p;
    bit een;
    @(negedge clk_i);
    tick_i = t; rate_sel_i = 4'(sel); pie_i = en; cfg_wr_i = wr;
    esel = wr ? sel : m_sel;
    een  = wr ? en : m_en;
    if (t) m_cnt = (m_cnt + 1) % 32768;
    p = per_of(esel, een);
    e.evt = t && (p != 0) && (m_cnt % (p == 0 ? 1 : p) == 0);
    if (wr) begin m_sel = sel; m_en = en; end
    e.per = per_of(m_sel, m_en);
    e.tag = tag;
    q.push_back(e);
  endtask

  always @(posedge clk_i) begin
    exp_t e;
    #2;
    if (q.size() > 0) begin
      e = q.pop_front();
      chk({e.tag, " evt"}, int'(evt_o), int'(e.evt));
      chk({e.tag, " period"}, int'(period_o), e.per);
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk("R1 evt", int'(evt_o), 0);
    chk("R1 period", int'(period_o), 0);
    tag = "R1";  // counter starts at 0: first event after 4 ticks
    step(1, 3, 1, 1);
    for (int i = 0; i < 7; i++) step(1, 3, 1, 0);
    tag = "R5";
    for (int i = 0; i < 40; i++) step(1, 3, 1, 0);
    tag = "R8";  // inputs move without the strobe
    for (int i = 0; i < 20; i++) step(1, 9 + (i % 3), i % 2, 0);
    tag = "R4";
    step(1, 3, 0, 1);
    for (int i = 0; i < 20; i++) step(1, 3, 0, 0);
    tag = "R3";
    step(1, 0, 1, 1);
    for (int i = 0; i < 20; i++) step(1, 0, 1, 0);
    tag = "R6";
    step(1, 1, 1, 1);
    for (int i = 0; i < 300; i++) step(1, 1, 1, 0);
    step(1, 2, 1, 1);
    for (int i = 0; i < 600; i++) step(1, 2, 1, 0);
    tag = "R2";  // sparse ticks
    step(0, 4, 1, 1);
    for (int i = 0; i < 60; i++) step(i % 3 == 0, 4, 1, 0);
    tag = "R7";  // write off the grid
    for (int i = 0; i < 3; i++) step(1, 4, 1, 0);
    step(1, 5, 1, 1);
    for (int i = 0; i < 60; i++) step(1, 5, 1, 0);
    tag = "R9";
    step(1, 3, 1, 1);
    for (int i = 0; i < 20; i++) begin
      bit due = ((m_cnt + 1) % 4 == 0);
      step(1, 3, !due, 1);
    end
    tag = "R10";
    for (int i = 0; i < 30; i++) step(i % 2, 3, 1, i == 0);
    tag = "R11";
    step(0, 6, 1, 1);
    step(0, 7, 1, 1);
    step(0, 7, 1, 0);
    step(0, 14, 0, 1);
    step(0, 14, 1, 1);
    tag = "R5";  // longest period across the counter wrap
    step(1, 15, 1, 1);
    for (int i = 0; i < 33000; i++) step(1, 15, 1, 0);
    @(negedge clk_i);
    tick_i = 0; cfg_wr_i = 0;
    repeat (3) @(negedge clk_i);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule